// File: doc/BRIEF.md
# Multi-CPU Passive Release Filter

This block sits in a system bridge between several CPUs and a remote interrupt controller whose vector reads cross two buses and are costly. When an interrupt is pending, more than one CPU may try to fetch its vector at once. Only the first of these reads is passed on to the controller. Every other reader is answered straight away by the bridge with a fixed release code, which means "nothing more is pending", so that CPU can go back to other work.

Each CPU issues a vector read as a one-cycle pulse on its request line. A read that is not forwarded gets its response in the next cycle. The read that is forwarded raises a one-cycle downstream request. Its response is delivered to the owning CPU in the cycle after the controller returns the vector. A CPU does not issue a new read while its own forwarded read is still outstanding.

Top module: `irq_release_filter`

## Requirements
- R1: After reset, no CPU response is valid and the downstream request is low.
- R2: While the pending input stays high, only the first accepted read is forwarded downstream. Every later read is answered with the release code until pending drops.
- R3: When several CPUs request in the same cycle and a forward is possible, the lowest-indexed CPU is forwarded. All the others are released.
- R4: A read that is not forwarded produces a valid response with the release code (parameter, default 0x07) in the cycle after the request. Slot i of the vector bus is bits [i*8 +: 8].
- R5: When the downstream acknowledge arrives, the returned vector is delivered to the owner's slot only, in the following cycle.
- R6: A read that arrives while pending is low is released and never forwarded.
- R7: Pending going low clears the serviced state. The first read after pending rises again is forwarded.
- R8: While a forwarded read is outstanding, every new read is released, even if pending has toggled in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pending_i | input | 1 | Interrupt pending from controller |
| cpu_req_i | input | NUM_CPU | Per-CPU vector-read pulse |
| cpu_rsp_valid_o | output | NUM_CPU | Per-CPU response valid |
| cpu_rsp_vec_o | output | NUM_CPU*VEC_W | Per-CPU response vector, slot i at [i*VEC_W +: VEC_W] |
| ds_req_o | output | 1 | Downstream vector-read pulse |
| ds_ack_i | input | 1 | Downstream vector returned |
| ds_vec_i | input | VEC_W | Downstream vector value |

## Verification
Directed sequences cover the following cases:
- A lone reader.
- A follower arriving while the owner's read is in flight.
- A reader arriving after the owner has been served but while pending is still high.
- A pending drop followed by a fresh rise.
- Two, and then four, simultaneous readers.
- Readers arriving while pending is low.

Between them, these separate the forward-once behaviour from simple per-request forwarding, the priority choice from any-winner selection, and the pending gating from the serviced flag. Seeded random traffic then mixes overlapping requests, acknowledges and pending toggles. This exposes any slot mix-up between the owner's vector and release codes.

// File: rtl/irq_rel_pkg.sv
package irq_rel_pkg;
    localparam int unsigned DEF_CPUS    = 4;
    localparam int unsigned DEF_VEC_W   = 8;
    localparam logic [7:0]  DEF_RELEASE = 8'h07;
endpackage

// File: rtl/irq_rel_prio.sv
module irq_rel_prio #(
    parameter int unsigned N  = 4,
    parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic          any_o,
    output logic [N-1:0]  grant_o,
    output logic [IW-1:0] idx_o
);
    logic [N:0] seen;
    assign seen[0] = 1'b0;

    for (genvar g = 0; g < N; g++) begin : g_chain
        assign grant_o[g]  = req_i[g] & ~seen[g];
        assign seen[g+1]   = seen[g] | req_i[g];
    end

    assign any_o = seen[N];

    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/irq_rel_service.sv
module irq_rel_service (
    input  logic clk,
    input  logic rst_n,
    input  logic pend_i,
    input  logic set_i,
    output logic serv_o
);
    logic serv_d, serv_q;

    always_comb begin
        serv_d = pend_i ? (serv_q | set_i) : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) serv_q <= 1'b0;
        else        serv_q <= serv_d;
    end

    assign serv_o = serv_q;

    // R7: a low pending input leaves nothing marked as serviced
    assert_clear_on_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_i |=> !serv_o);
    // R6: a forward is only ever requested while pending is high
    assert_set_needs_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |-> pend_i);
endmodule

// File: rtl/irq_release_filter.sv
module irq_release_filter
    import irq_rel_pkg::*;
#(
    parameter int unsigned   NUM_CPU      = DEF_CPUS,
    parameter int unsigned   VEC_W        = DEF_VEC_W,
    parameter logic [VEC_W-1:0] RELEASE_CODE = VEC_W'(DEF_RELEASE)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     irq_pending_i,
    input  logic [NUM_CPU-1:0]       cpu_req_i,
    output logic [NUM_CPU-1:0]       cpu_rsp_valid_o,
    output logic [NUM_CPU*VEC_W-1:0] cpu_rsp_vec_o,
    output logic                     ds_req_o,
    input  logic                     ds_ack_i,
    input  logic [VEC_W-1:0]         ds_vec_i
);
    localparam int unsigned IW = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

    typedef struct packed {
        logic                     busy;
        logic [IW-1:0]            owner;
        logic                     ds_req;
        logic [NUM_CPU-1:0]       rsp_v;
        logic [NUM_CPU*VEC_W-1:0] rsp_vec;
    } state_t;

    state_t st_d, st_q;

    logic               any_req;
    logic [NUM_CPU-1:0] grant;
    logic [IW-1:0]      win_idx;
    logic               serviced;
    logic               fwd;

    irq_rel_prio #(.N(NUM_CPU), .IW(IW)) u_prio (
        .req_i   (cpu_req_i),
        .any_o   (any_req),
        .grant_o (grant),
        .idx_o   (win_idx)
    );

    irq_rel_service u_serv (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (irq_pending_i),
        .set_i  (fwd),
        .serv_o (serviced)
    );

    assign fwd = irq_pending_i & ~serviced & ~st_q.busy & any_req;

    always_comb begin
        st_d        = st_q;
        st_d.ds_req = 1'b0;
        st_d.rsp_v  = '0;
        if (st_q.busy && ds_ack_i) begin
            st_d.busy = 1'b0;
            for (int i = 0; i < NUM_CPU; i++) begin
                if (i == int'(st_q.owner)) begin
                    st_d.rsp_v[i]                 = 1'b1;
                    st_d.rsp_vec[i*VEC_W +: VEC_W] = ds_vec_i;
                end
            end
        end
        for (int i = 0; i < NUM_CPU; i++) begin
            if (cpu_req_i[i] && !(fwd && grant[i])) begin
                st_d.rsp_v[i]                 = 1'b1;
                st_d.rsp_vec[i*VEC_W +: VEC_W] = RELEASE_CODE;
            end
        end
        if (fwd) begin
            st_d.busy   = 1'b1;
            st_d.owner  = win_idx;
            st_d.ds_req = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cpu_rsp_valid_o = st_q.rsp_v;
    assign cpu_rsp_vec_o   = st_q.rsp_vec;
    assign ds_req_o        = st_q.ds_req;

    // R2: never two downstream reads back to back
    assert_single_forward_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ds_req_o |=> !ds_req_o);
    // R6: pending low yields no forward in the next cycle
    assert_idle_no_forward_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_pending_i |=> !ds_req_o);
    // R5: an acknowledged downstream read produces a response next cycle
    assert_owner_served_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && ds_ack_i) |=> ($countones(cpu_rsp_valid_o) >= 1));
    // R8: no new forward while one is outstanding
    assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !ds_ack_i) |=> !ds_req_o);

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_chk
        // R4: a released reader sees the release code one cycle later
        assert_release_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_req_i[g] && !grant[g]) |=>
            (cpu_rsp_valid_o[g] && cpu_rsp_vec_o[g*VEC_W +: VEC_W] == RELEASE_CODE));
    end
endmodule

// File: tb/tb_irq_release_filter.sv
`timescale 1ns/1ps
module tb_irq_release_filter;
    localparam int N = 4;
    localparam int W = 8;
    localparam logic [7:0] REL = 8'h07;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pend = 1'b0;
    logic [N-1:0] req = '0;
    logic [N-1:0] rsp_v;
    logic [N*W-1:0] rsp_vec;
    logic ds_req;
    logic ack = 1'b0;
    logic [W-1:0] vec = '0;

    int total = 0;
    int bad = 0;
    bit m_serv = 0, m_busy = 0;
    int m_owner = 0;

    always #2.5 clk = ~clk;

    irq_release_filter dut (
        .clk(clk), .rst_n(rst_n), .irq_pending_i(pend), .cpu_req_i(req),
        .cpu_rsp_valid_o(rsp_v), .cpu_rsp_vec_o(rsp_vec), .ds_req_o(ds_req),
        .ds_ack_i(ack), .ds_vec_i(vec));

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit p, input logic [N-1:0] r, input bit a,
                        input logic [W-1:0] v, input string tag);
        logic [N-1:0] ev;
        logic [W-1:0] evec [N];
        bit fwd;
        int win;
        pend = p; req = r; ack = a; vec = v;
        ev = '0; fwd = 0; win = -1;
        for (int i = 0; i < N; i++) evec[i] = '0;
        if (m_busy && a) begin
            ev[m_owner] = 1'b1; evec[m_owner] = v;
        end
        for (int i = N - 1; i >= 0; i--) if (r[i]) win = i;
        for (int i = 0; i < N; i++) begin
            if (r[i]) begin
                if (i == win && p && !m_serv && !m_busy) fwd = 1;
                else begin ev[i] = 1'b1; evec[i] = REL; end
            end
        end
        if (m_busy && a) m_busy = 0;
        if (fwd) begin m_busy = 1; m_owner = win; m_serv = 1; end
        if (!p) m_serv = 0;
        @(posedge clk); @(negedge clk);
        chk(tag, "ds_req", int'(ds_req), int'(fwd));
        chk(tag, "rsp_valid", int'(rsp_v), int'(ev));
        for (int i = 0; i < N; i++)
            if (ev[i]) chk(tag, "rsp_vec", int'(rsp_vec[i*W +: W]), int'(evec[i]));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        chk("R1", "rsp_valid", int'(rsp_v), 0);
        chk("R1", "ds_req", int'(ds_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ds_req_after", int'(ds_req), 0);
        // first reader forwarded
        step(1, 4'b0001, 0, 8'h00, "R2");
        // follower while owner outstanding
        step(1, 4'b0010, 0, 8'h00, "R8");
        // controller returns vector to owner
        step(1, 4'b0000, 1, 8'h41, "R5");
        // still pending and serviced: released
        step(1, 4'b0100, 0, 8'h00, "R2");
        step(1, 4'b0000, 0, 8'h00, "R4");
        // drop pending, then new rise with two readers
        step(0, 4'b0000, 0, 8'h00, "R7");
        step(1, 4'b1100, 0, 8'h00, "R3");
        step(1, 4'b0000, 1, 8'h55, "R5");
        // owner outstanding across a pending toggle
        step(0, 4'b0000, 0, 8'h00, "R7");
        step(1, 4'b0001, 0, 8'h00, "R7");
        step(0, 4'b0000, 0, 8'h00, "R8");
        step(1, 4'b0010, 0, 8'h00, "R8");
        step(1, 4'b0000, 1, 8'h66, "R5");
        // idle controller: everyone released
        step(0, 4'b1111, 0, 8'h00, "R6");
        step(1, 4'b1111, 0, 8'h00, "R3");
        step(1, 4'b0000, 1, 8'h77, "R5");
        step(0, 4'b0000, 0, 8'h00, "R7");
        for (int k = 0; k < 3000; k++) begin
            bit p;
            logic [N-1:0] r;
            bit a;
            p = ($urandom % 6) != 0;
            r = (($urandom % 3) == 0) ? N'($urandom % 16) : '0;
            if (m_busy) r[m_owner] = 1'b0;
            a = m_busy && (($urandom % 3) == 0);
            step(p, r, a, W'($urandom), "R2");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule